// File: doc/BRIEF.md
# Serial LED Driver Shift Datapath

This block is the digital core of a serial constant-current LED driver. A chain of such blocks is fed one bit per clock on a serial input, and each block passes the bit that fell off its top on to the next block. A load strobe copies the shift register into one of two parallel holding registers. In normal operation that is the channel latch, which sets the 16 channel enables. In special operation it is the configuration latch, whose value sets the output current gain.

In special operation the shift register also carries diagnostics. When the active-low output enable has been held low for long enough, the register takes in a parallel error-status word in place of serial data. Once the enable goes high again, that word can be clocked out serially. The operating mode arrives on an input pin, because mode-switch detection is done by a separate block. The active-low enable also gates every channel output.

Top module: `led_shift_datapath`

## Requirements
- R1: On each rising clock edge, without a parallel load, the register shifts toward its MSB and takes `sdi` into bit 0. `sdo` is the MSB, so the bit taken in at edge k appears on `sdo` after edge k+15.
- R2: In normal mode (`special`=0), `le` high at a rising edge copies the register contents held before that edge into the channel latch. The configuration latch does not change.
- R3: In special mode, `le` high at a rising edge copies the register contents held before that edge into the configuration latch. The channel latch does not change.
- R4: The configuration latch, visible on `cfg_code`, holds its value through any number of edges without a special-mode load. This includes mode changes and normal-mode loads.
- R5: While `oe_n` is 1, `ch_on` is all zeros, whatever the channel latch holds.
- R6: While `oe_n` is 0, `ch_on` equals the channel latch. Bit i drives channel i.
- R7: In special mode, the first and second consecutive edges with `oe_n` low still shift `sdi` in.
- R8: In special mode, the third and every later consecutive edge with `oe_n` low loads `err_status` into the register, with bit i going to register bit i. `sdi` is ignored on those edges.
- R9: After `oe_n` returns high in special mode, serial shifting from `sdi` resumes. The captured status leaves on `sdo` MSB first.
- R10: In normal mode, `oe_n` low for any number of edges never loads `err_status`. Shifting from `sdi` continues.
- R11: The low-sample count saturates during long low periods and returns to zero on any edge with `oe_n` high. A new low period therefore again shifts `sdi` for its first two edges.
- R12: Synchronous reset (`rst`=1 at an edge) clears the shift register, the channel latch, the configuration latch and the low-sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| special | input | 1 | Operating mode: 0 normal, 1 special |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Load strobe, sampled at rising edge |
| oe_n | input | 1 | Active-low output enable and diagnostic trigger |
| err_status | input | WIDTH | Parallel per-channel error-status word |
| sdo | output | 1 | Serial data out (register MSB) |
| ch_on | output | WIDTH | Gated channel enables |
| cfg_code | output | WIDTH | Stored configuration code |

## Verification
The bench targets the boundary between the second and third low enable samples in special mode. A design that loads status one edge too early loses an SDI bit, and one that loads one edge too late keeps it. Both show up in the serial stream that is read back afterwards. The bench also holds the enable low for a long stretch in normal mode, where a design that ignores the mode would corrupt the data. It interleaves loads of both latches across mode changes to catch a strobe that reaches the wrong latch. Finally, it breaks a low period with a single high sample, which exposes a counter that fails to clear.

// File: rtl/led_shift_datapath.sv
module led_shift_datapath #(
  parameter int WIDTH = 16,
  parameter int LOAD_AFTER = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             special,
  input  logic             sdi,
  input  logic             le,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] err_status,
  output logic             sdo,
  output logic [WIDTH-1:0] ch_on,
  output logic [WIDTH-1:0] cfg_code
);
  localparam int CW = $clog2(LOAD_AFTER + 2);
  localparam logic [CW-1:0] CMAX = CW'(LOAD_AFTER + 1);
  localparam logic [CW-1:0] CLOAD = CW'(LOAD_AFTER);

  logic [WIDTH-1:0] sr, lat;
  logic [CW-1:0]    lo_cnt;
  logic             grab;

  assign grab  = special && !oe_n && (lo_cnt >= CLOAD);
  assign sdo   = sr[WIDTH-1];
  assign ch_on = oe_n ? '0 : lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      lat      <= '0;
      cfg_code <= '0;
      lo_cnt   <= '0;
    end else begin
      sr <= grab ? err_status : {sr[WIDTH-2:0], sdi};
      if (le && special)  cfg_code <= sr;
      if (le && !special) lat      <= sr;
      if (oe_n)                lo_cnt <= '0;
      else if (lo_cnt != CMAX) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  // R1 R7 R10
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    !(special && !oe_n && lo_cnt >= CLOAD) |=> sr[0] == $past(sdi));

  // R2
  normal_load_chk: assert property (@(posedge clk) disable iff (rst)
    (le && !special) |=> (lat == $past(sr)) && $stable(cfg_code));

  // R3
  special_load_chk: assert property (@(posedge clk) disable iff (rst)
    (le && special) |=> (cfg_code == $past(sr)) && $stable(lat));

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(le && special) |=> $stable(cfg_code));

  // R8
  status_load_chk: assert property (@(posedge clk) disable iff (rst)
    (special && !oe_n && $past(!oe_n) && $past(!oe_n, 2) && $past(!rst) && $past(!rst, 2))
      |=> sr == $past(err_status));

  // R11
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> lo_cnt == '0);
endmodule

// File: tb/tb_led_shift_datapath.sv
module tb_led_shift_datapath;
  localparam int W = 16;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0, rst = 1'b1, special = 1'b0, sdi = 1'b0, le = 1'b0, oe_n = 1'b1;
  logic [W-1:0] err_status = '0;
  logic sdo;
  logic [W-1:0] ch_on, cfg_code;

  led_shift_datapath #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .special(special), .sdi(sdi), .le(le), .oe_n(oe_n),
    .err_status(err_status), .sdo(sdo), .ch_on(ch_on), .cfg_code(cfg_code));

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic sdo;
    logic [W-1:0] ch;
    logic [W-1:0] cfg;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  logic [W-1:0] m_sr = '0, m_lat = '0, m_cfg = '0;
  int m_cnt = 0;

  task automatic step(input logic r, input logic sp, input logic d, input logic l,
                      input logic oe, input logic [W-1:0] es, input string tag);
    exp_t e;
    logic [W-1:0] nsr;
    @(negedge clk);
    rst = r; special = sp; sdi = d; le = l; oe_n = oe; err_status = es;
    @(posedge clk);
    if (r) begin
      m_sr = '0; m_lat = '0; m_cfg = '0; m_cnt = 0;
    end else begin
      nsr = (sp && !oe && m_cnt >= 2) ? es : {m_sr[W-2:0], d};
      if (l && sp) m_cfg = m_sr;
      if (l && !sp) m_lat = m_sr;
      m_cnt = oe ? 0 : (m_cnt == 3 ? 3 : m_cnt + 1);
      m_sr = nsr;
    end
    e.sdo = m_sr[W-1]; e.ch = oe ? '0 : m_lat; e.cfg = m_cfg; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic shift_word(input logic sp, input logic oe, input logic [W-1:0] v, input string tag);
    for (int i = W-1; i >= 0; i--) step(1'b0, sp, v[i], 1'b0, oe, '0, tag);
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks += 3;
      if (sdo !== e.sdo) begin
        errors++; $display("FAIL %s sdo actual=%b expected=%b", e.tag, sdo, e.sdo);
      end
      if (ch_on !== e.ch) begin
        errors++; $display("FAIL %s ch_on actual=%h expected=%h", e.tag, ch_on, e.ch);
      end
      if (cfg_code !== e.cfg) begin
        errors++; $display("FAIL %s cfg_code actual=%h expected=%h", e.tag, cfg_code, e.cfg);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R12 reset state
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF, "R12");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF, "R12");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R12");
    // R1 shift and SDO delay, R2 normal load, R6 enable
    shift_word(1'b0, 1'b1, 16'hA5C3, "R1");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, '0, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R6");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0, "R5");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R6");
    // R10 normal mode long low enable keeps shifting
    shift_word(1'b0, 1'b0, 16'h1E73, "R10");
    shift_word(1'b0, 1'b0, 16'h0000, "R10");
    // R3 special load into configuration latch
    shift_word(1'b1, 1'b1, 16'h3C96, "R1");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '0, "R3");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R3");
    // R7 R8 status capture, SDI held 1
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '0, "R7");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h1111, "R7");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h2222, "R7");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'hBEEF, "R8");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h4D2B, "R8");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h8E61, "R11");
    // R9 read back status
    shift_word(1'b1, 1'b1, 16'h0000, "R9");
    // R11 single high sample clears count
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF, "R11");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, "R11");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFFF, "R11");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, "R11");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF, "R11");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF, "R11");
    shift_word(1'b1, 1'b1, 16'h0000, "R11");
    // R4 configuration held across normal loads and mode changes
    shift_word(1'b0, 1'b1, 16'h7A05, "R4");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R4");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R4");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '0, "R4");
    // R12 reset after activity
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R12");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R12");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule